// File: doc/BRIEF.md
# Ethernet Frame Transmitter with Dibit Line Output

This block sends one complete Ethernet frame over a two-bit-wide transmit line that is clocked once per dibit. A single-cycle start pulse gives a byte offset and a payload length. The payload sits in an external byte-wide circular buffer, and the block reads it through a synchronous read port with one cycle of latency. The block first sends a fixed preamble and a start delimiter. It then sends the payload, starting at the offset and wrapping at the end of the buffer.

If the payload is shorter than the minimum frame body, the block fills it with zero bytes. The frame check sequence is computed as the bytes go out, so the block needs no second pass over the buffer and no frame-sized store. While a frame is in flight, the block holds a busy flag and ignores further start pulses. Between frames the line stays idle.

Top module: `eth_dibit_tx`

## Requirements
- R1: Every frame opens with seven bytes of value 0x55 and then one byte of value 0xD5. The first dibit of the first 0x55 appears in the cycle after the accepted start pulse.
- R2: Each byte is sent as four dibits, in the order bits [1:0], [3:2], [5:4], [7:6]. `line_dibit_o[0]` carries the lower bit of each pair.
- R3: Payload byte i is read from buffer address (offset + i) modulo 128, so reading wraps from address 127 to address 0. The address is presented on `rd_addr_o` during the third dibit of the byte sent before it. The read data is taken from `rd_data_i` one cycle later.
- R4: If the length is below 60, the body is extended with 0x00 bytes up to 60 bytes. This holds whatever the buffer contains past the payload.
- R5: The body is followed by four check bytes. The check is a reflected CRC-32 with polynomial 0x04C11DB7 (reflected form 0xEDB88320), seeded with 0xFFFFFFFF and taken over the payload and padding. It is sent complemented, least significant byte first. A CRC run over the body plus the four check bytes therefore ends with the register at 0xDEBB20E3.
- R6: `line_en_o` is high in exactly the cycles that carry preamble, delimiter, body or check dibits. A frame therefore lasts 4 × (12 + max(length, 60)) cycles. `line_dibit_o` is 00 whenever `line_en_o` is low.
- R7: `busy_o` rises in the cycle after an accepted start pulse. It stays high through the cycle that carries the last check dibit and is low in the cycle after that.
- R8: A start pulse that arrives while `busy_o` is high is ignored. The frame in flight continues unchanged, and no new frame begins after it.
- R9: After reset, `busy_o`, `line_en_o` and `line_dibit_o` are all 0 and `rd_addr_o` is 0.
- R10: A length of zero gives a frame whose body is 60 bytes of 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line clock, one dibit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle request to send a frame |
| offset_i | input | 7 | Buffer address of the first payload byte |
| length_i | input | 11 | Payload length in bytes |
| rd_addr_o | output | 7 | Read address to the payload buffer |
| rd_data_i | input | 8 | Read data, valid one cycle after the address |
| busy_o | output | 1 | High while a frame is being sent |
| line_en_o | output | 1 | Transmit enable on the line |
| line_dibit_o | output | 2 | Transmit dibit on the line |

## Verification
The bench sends frames whose payloads start near the top of the buffer, so that reading wraps. If the wrap or the read latency were wrong, the design would send stale or shifted bytes and the dibit stream would diverge from the scoreboard. The buffer is filled with nonzero bytes, so padding that leaks buffer data shows up directly. A zero-length frame, a frame of exactly 60 bytes and a frame longer than the buffer cover the edges of the padding decision. Every frame's check bytes are confirmed twice: by the scoreboard, and by the fixed CRC residue over the received bytes. A start pulse sent mid-frame must not shorten, restart or extend the frame that is already in flight.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_SFD,
    PH_DATA,
    PH_FCS
  } phase_t;

  localparam logic [7:0]  PRE_BYTE      = 8'h55;
  localparam logic [7:0]  SFD_BYTE      = 8'hD5;
  localparam int          PRE_COUNT     = 7;
  localparam int          MIN_BODY      = 60;
  localparam int          FCS_COUNT     = 4;
  localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

  // One byte through the reflected CRC-32, low bit first.
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

  // Dibit number idx of a byte, lowest pair first.
  function automatic logic [1:0] pick_dibit(input logic [7:0] b, input logic [1:0] idx);
    logic [7:0] s;
    s = b >> {idx, 1'b0};
    return s[1:0];
  endfunction
endpackage

// File: rtl/eth_buf_addr.sv
module eth_buf_addr #(
  parameter int DEPTH  = 128,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              adv,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (load)   ptr <= load_val;
    else if (adv)    ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  assign ptr_o = ptr;

  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && ptr == LAST) |=> (ptr == '0)); // R3
endmodule

// File: rtl/eth_crc32_unit.sv
module eth_crc32_unit
  import eth_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        adv,
  input  logic [7:0]  byte_i,
  output logic [31:0] crc_q,
  output logic [31:0] crc_next
);
  logic [31:0] crc;

  assign crc_next = crc32_step(crc, byte_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc <= CRC_SEED;
    else if (clear) crc <= CRC_SEED;
    else if (adv)   crc <= crc_next;
  end

  assign crc_q = crc;

  AST_CRC_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (crc_q == CRC_SEED)); // R5
endmodule

// File: rtl/eth_dibit_ser.sv
module eth_dibit_ser
  import eth_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       run,
  input  logic [7:0] load_byte,
  output logic [7:0] byte_o,
  output logic [1:0] idx_o,
  output logic [1:0] dibit_o,
  output logic       last_o,
  output logic       fetch_o
);
  logic [7:0] cur;
  logic [1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0;
      idx <= '0;
    end else if (start) begin
      cur <= load_byte;
      idx <= '0;
    end else if (run) begin
      idx <= idx + 2'd1;
      if (idx == 2'd3) cur <= load_byte;
    end
  end

  assign byte_o  = cur;
  assign idx_o   = idx;
  assign dibit_o = pick_dibit(cur, idx);
  assign last_o  = (idx == 2'd3);
  assign fetch_o = (idx == 2'd2);

  AST_DIBIT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start) |=> (idx_o == $past(idx_o) + 2'd1)); // R2
endmodule

// File: rtl/eth_dibit_tx.sv
module eth_dibit_tx
  import eth_tx_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int LEN_W  = 11,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [LEN_W-1:0]  length_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              busy_o,
  output logic              line_en_o,
  output logic [1:0]        line_dibit_o
);
  localparam int CW = LEN_W + 1;
  localparam logic [CW-1:0] MIN_BODY_C  = CW'(MIN_BODY);
  localparam logic [CW-1:0] PRE_LAST_C  = CW'(PRE_COUNT - 1);
  localparam logic [CW-1:0] FCS_LAST_C  = CW'(FCS_COUNT - 1);

  phase_t          phase;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   len_q;

  // Named internal events.
  logic            running;
  logic            start_acc;
  logic            byte_done;
  logic            fetch_slot;
  logic            frame_done;
  logic            crc_adv;
  logic            next_from_mem;

  logic [CW-1:0]   cnt_nx;
  logic [CW-1:0]   body_len;
  logic            pre_last;
  logic            data_last;
  logic            fcs_last;
  logic [7:0]      next_byte;

  logic [7:0]      ser_byte;
  logic [1:0]      ser_idx;
  logic [1:0]      ser_dibit;
  logic            ser_last;
  logic            ser_fetch;
  logic [31:0]     crc_q;
  logic [31:0]     crc_next;
  logic [31:0]     fcs_shift;

  assign running   = (phase != PH_IDLE);
  assign start_acc = start_i && !running;
  assign cnt_nx    = cnt + 1'b1;
  assign body_len  = (len_q < MIN_BODY_C) ? MIN_BODY_C : len_q;
  assign pre_last  = (cnt == PRE_LAST_C);
  assign data_last = (cnt_nx >= body_len);
  assign fcs_last  = (cnt == FCS_LAST_C);

  assign next_from_mem = ((phase == PH_SFD) && (len_q != '0)) ||
                         ((phase == PH_DATA) && !data_last && (cnt_nx < len_q));

  assign byte_done  = running && ser_last;
  assign fetch_slot = running && ser_fetch && next_from_mem;
  assign frame_done = byte_done && (phase == PH_FCS) && fcs_last;
  assign crc_adv    = byte_done && (phase == PH_DATA);
  assign fcs_shift  = crc_q >> {cnt[1:0] + 2'd1, 3'b000};

  always_comb begin
    next_byte = 8'h00;
    unique case (phase)
      PH_IDLE: next_byte = PRE_BYTE;
      PH_PRE:  next_byte = pre_last ? SFD_BYTE : PRE_BYTE;
      PH_SFD:  next_byte = (len_q != '0) ? rd_data_i : 8'h00;
      PH_DATA: begin
        if (data_last)           next_byte = ~crc_next[7:0];
        else if (cnt_nx < len_q) next_byte = rd_data_i;
        else                     next_byte = 8'h00;
      end
      PH_FCS:  next_byte = ~fcs_shift[7:0];
      default: next_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      len_q <= '0;
    end else if (start_acc) begin
      phase <= PH_PRE;
      cnt   <= '0;
      len_q <= CW'(length_i);
    end else if (byte_done) begin
      unique case (phase)
        PH_PRE: begin
          if (pre_last) begin phase <= PH_SFD; cnt <= '0; end
          else cnt <= cnt_nx;
        end
        PH_SFD: begin
          phase <= PH_DATA;
          cnt   <= '0;
        end
        PH_DATA: begin
          if (data_last) begin phase <= PH_FCS; cnt <= '0; end
          else cnt <= cnt_nx;
        end
        PH_FCS: begin
          if (fcs_last) begin phase <= PH_IDLE; cnt <= '0; end
          else cnt <= cnt_nx;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  eth_buf_addr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_acc),
    .load_val (offset_i),
    .adv      (fetch_slot),
    .ptr_o    (rd_addr_o)
  );

  eth_crc32_unit i_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start_acc),
    .adv      (crc_adv),
    .byte_i   (ser_byte),
    .crc_q    (crc_q),
    .crc_next (crc_next)
  );

  eth_dibit_ser i_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_acc),
    .run       (running),
    .load_byte (next_byte),
    .byte_o    (ser_byte),
    .idx_o     (ser_idx),
    .dibit_o   (ser_dibit),
    .last_o    (ser_last),
    .fetch_o   (ser_fetch)
  );

  assign busy_o       = running;
  assign line_en_o    = running;
  assign line_dibit_o = running ? ser_dibit : 2'b00;

  AST_PRE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (line_en_o && line_dibit_o == 2'b01 && ser_idx == 2'd0)); // R1
  AST_FETCH_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_slot |=> byte_done); // R3
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !frame_done) |=> running); // R7
  AST_FRAME_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !busy_o); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (running && start_i) |=> $stable(len_q)); // R8
endmodule

// File: tb/test_eth_dibit_tx.sv
module test_eth_dibit_tx;
  localparam int DEPTH = 128;
  localparam int LEN_W = 11;
  localparam int AW    = 7;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          start_i = 0;
  logic [AW-1:0] offset_i = '0;
  logic [LEN_W-1:0] length_i = '0;
  logic [AW-1:0] rd_addr_o;
  logic [7:0]    rd_data_i;
  logic          busy_o;
  logic          line_en_o;
  logic [1:0]    line_dibit_o;

  always #5 clk = ~clk;

  logic [7:0] mem [DEPTH];
  logic [7:0] mem_q = '0;
  always @(posedge clk) mem_q <= mem[rd_addr_o];
  assign rd_data_i = mem_q;

  eth_dibit_tx #(.DEPTH(DEPTH), .LEN_W(LEN_W)) i_eth_dibit_tx (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .offset_i(offset_i),
    .length_i(length_i), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .busy_o(busy_o), .line_en_o(line_en_o), .line_dibit_o(line_dibit_o)
  );

  int checks = 0;
  int errors = 0;
  logic [1:0] exp_q [$];
  logic [1:0] rx_q  [$];
  logic [1:0] mon_exp;
  bit mon_on = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Bit-serial reference CRC, written independently of the design.
  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c;
    for (int k = 0; k < 8; k++) begin
      logic fb = r[0] ^ b[k];
      r = {1'b0, r[31:1]};
      if (fb) r = r ^ 32'hEDB88320;
    end
    return r;
  endfunction

  // Monitor: pops the scoreboard whenever the line is enabled (R2, R6).
  always @(negedge clk) begin
    if (mon_on) begin
      if (line_en_o) begin
        rx_q.push_back(line_dibit_o);
        if (exp_q.size() == 0) begin
          check(0, "R6 extra dibit", line_dibit_o, 0);
        end else begin
          mon_exp = exp_q.pop_front();
          check(line_dibit_o == mon_exp, "R2 dibit stream", line_dibit_o, mon_exp);
        end
      end else begin
        check(line_dibit_o == 2'b00, "R6 idle dibit", line_dibit_o, 0);
      end
    end
  end

  task automatic push_byte(input logic [7:0] b);
    for (int k = 0; k < 4; k++) exp_q.push_back(2'((b >> (2 * k)) & 8'h03));
  endtask

  task automatic send_frame(input int off, input int len, input bit poke);
    int body = (len < 60) ? 60 : len;
    logic [31:0] c = 32'hFFFFFFFF;
    logic [31:0] res = 32'hFFFFFFFF;
    logic [7:0] b;
    int n = 0;
    int nbytes;
    logic [7:0] rb [$];
    for (int i = 0; i < 7; i++) push_byte(8'h55);
    push_byte(8'hD5);
    for (int i = 0; i < body; i++) begin
      b = (i < len) ? mem[(off + i) % DEPTH] : 8'h00;
      c = ref_crc(c, b);
      push_byte(b);
    end
    c = ~c;
    for (int i = 0; i < 4; i++) push_byte(c[8*i +: 8]);
    rx_q.delete();
    @(negedge clk);
    start_i = 1; offset_i = AW'(off); length_i = LEN_W'(len);
    @(negedge clk);
    start_i = 0;
    check(busy_o == 1, "R7 busy after start", busy_o, 1);
    n = 1;
    while (busy_o && n < 20000) begin
      if (poke && n == 30) begin
        start_i = 1; offset_i = 7'd3; length_i = 11'd5;
      end else begin
        start_i = 0;
      end
      @(negedge clk);
      if (busy_o) n++;
    end
    start_i = 0;
    check(n == 4 * (12 + body), "R7 busy length", n, 4 * (12 + body));
    check(exp_q.size() == 0, "R6 missing dibits", exp_q.size(), 0);
    check(rx_q.size() == 4 * (12 + body), "R6 enable length", rx_q.size(), 4 * (12 + body));
    nbytes = rx_q.size() / 4;
    for (int j = 0; j < nbytes; j++)
      rb.push_back({rx_q[4*j+3], rx_q[4*j+2], rx_q[4*j+1], rx_q[4*j]});
    for (int j = 0; j < 7 && j < nbytes; j++)
      check(rb[j] == 8'h55, "R1 preamble", rb[j], 8'h55);
    if (nbytes > 7) check(rb[7] == 8'hD5, "R1 delimiter", rb[7], 8'hD5);
    for (int j = 8 + len; j < 8 + 60 && j < nbytes; j++)
      check(rb[j] == 8'h00, (len == 0) ? "R10 zero body" : "R4 pad byte", rb[j], 0);
    for (int j = 8; j < nbytes; j++) res = ref_crc(res, rb[j]);
    check(res == 32'hDEBB20E3, "R5 fcs residue", res, 32'hDEBB20E3);
    repeat (6) @(negedge clk);
    check(busy_o == 0, poke ? "R8 no extra frame" : "R7 idle after frame", busy_o, 0);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'((i * 29 + 7) | 8'h80);
    repeat (3) @(negedge clk);
    check(busy_o == 0, "R9 busy reset", busy_o, 0);
    check(line_en_o == 0, "R9 enable reset", line_en_o, 0);
    check(line_dibit_o == 0, "R9 dibit reset", line_dibit_o, 0);
    check(rd_addr_o == 0, "R9 address reset", rd_addr_o, 0);
    rst_n = 1;
    @(negedge clk);
    mon_on = 1;
    send_frame(120, 42, 0);   // R3 wrap, R4 padding
    send_frame(5, 60, 0);     // R4 exact minimum
    send_frame(0, 0, 0);      // R10 empty payload
    send_frame(50, 100, 0);   // R3 R5 longer body
    send_frame(100, 200, 0);  // R3 wraps more than once
    send_frame(10, 20, 1);    // R8 start while busy
    send_frame(127, 61, 0);   // R3 starts on the last address
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule